// File: doc/BRIEF.md
# Synthesizer Power-Up Register Sequencer

This block brings a fractional-N frequency synthesizer from power-up to a locked configuration. It drives the synthesizer's 24-bit serial programming port with a fixed series of register writes. Each write is shifted out on a clock line and a data line and committed by a latch-enable pulse. The order of the writes matters for safety. Test modes are cleared first and the noise mode is selected next. The divider counters are then held in reset while the reference divider and the feedback divider are loaded, and they are released only after those loads.

The sequence runs by itself when reset is released. It runs again on a start pulse once the previous run has finished. The caller supplies the register contents: the noise mode word, the control word, the reference-divider word, the modulus, the feedback-divider word, and an optional resync delay with its enable. The block forces the counter-reset bit, the load-select bit and the modulus field of each write. A done flag marks the end of the run.

Top module: `synth_init_seq`

## Requirements
- R1: The first rising edge at which `rst_n` is high is edge A. The first bit of a sequence is driven from edge A+2. Before that, all outputs are low. A start pulse sampled while `done_o` is high clears `done_o` at that edge and starts a new sequence, whose first bit is driven from the next edge.
- R2: Without resync, exactly six words are written in this order: all zeros, the noise word, the control word with counter reset, the reference-divider word, the feedback-divider word `n_word_i` unchanged, and the control word with counter reset released. The noise word is `noise_word_i` unchanged.
- R3: When `rsync_en_i` is 1, one extra reference-divider word follows the first control write. In that word bit 23 is 1 and the modulus field, bits [14:3], holds `rsync_dly_i`. The sequence then has seven words.
- R4: Bit 2 of the control word is forced to 1 in the first control write and to 0 in the last. All other bits come from `ctrl_word_i`.
- R5: In the normal reference-divider write, bit 23 is forced to 0 and bits [14:3] carry `modulus_i`. The remaining bits come from `r_word_i`.
- R6: Words go out MSB first. Each serial half period lasts `sclk_div_i`+1 clocks, and each bit takes a low half followed by a high half. `sdata_o` changes only while `sclk_o` is low.
- R7: After the 24th high half, `le_o` is high for exactly two half periods. Meanwhile `sclk_o` and `sdata_o` stay low.
- R8: After `le_o` falls, four half periods plus one clock pass with all serial lines low before the next word's first bit.
- R9: `done_o` rises one clock before the end of the last word's idle gap. It stays high until a start pulse is accepted.
- R10: A start pulse received while a sequence is running has no effect on the serial output or on `done_o`.
- R11: `sdata_o` is low whenever no bit is being shifted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when done |
| sclk_div_i | input | 8 | Serial half period minus one, in clocks |
| noise_word_i | input | 24 | Noise and spur mode register word |
| ctrl_word_i | input | 24 | Control register settings (bit 2 overridden) |
| r_word_i | input | 24 | Reference-divider register settings (bit 23 and bits [14:3] overridden) |
| modulus_i | input | 12 | Fractional modulus |
| rsync_dly_i | input | 12 | Phase resync delay interval |
| rsync_en_i | input | 1 | Insert the resync-delay write |
| n_word_i | input | 24 | Feedback-divider register word |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| le_o | output | 1 | Latch-enable strobe |
| done_o | output | 1 | Sequence complete |

## Verification
Let H = `sclk_div_i`+1 and P = 54H+1. The bench counts t in clocks from the edge that launches the first bit. Word w then starts at t = wP. Its half period h is (t - wP)/H. Bit 23-h/2 appears on `sdata_o` in halves 0 to 47, `le_o` is high in halves 48 and 49, and `done_o` is due at t = nP-1 for an n-word sequence. A behavioural model computes these values from the expected word list and compares every output at the falling edge of every clock. Each result is therefore checked in exactly the cycle the register chain makes it due, including the two reset-synchronizer cycles and the one-clock issue gap.

// File: rtl/isq_pkg.sv
package isq_pkg;
  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_LATCH, SH_GAP} sh_state_e;
  typedef enum logic [1:0] {CT_ISSUE, CT_WAIT, CT_DONE} ct_state_e;
  typedef enum logic [2:0] {
    ST_CLEAR, ST_NOISE, ST_CTRL_RST, ST_RSYNC, ST_RLOAD, ST_NLOAD, ST_CTRL_RUN
  } step_e;
endpackage

// File: rtl/isq_word_mux.sv
module isq_word_mux
  import isq_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int MOD_W     = 12,
  parameter int MOD_LSB   = 3,
  parameter int RLOAD_BIT = 23,
  parameter int CRST_BIT  = 2
) (
  input  step_e              step_i,
  input  logic [WORD_W-1:0]  noise_word_i,
  input  logic [WORD_W-1:0]  ctrl_word_i,
  input  logic [WORD_W-1:0]  r_word_i,
  input  logic [MOD_W-1:0]   modulus_i,
  input  logic [MOD_W-1:0]   rsync_dly_i,
  input  logic [WORD_W-1:0]  n_word_i,
  output logic [WORD_W-1:0]  word_o
);
  logic [WORD_W-1:0] r_built;
  logic [WORD_W-1:0] c_built;

  always_comb begin
    r_built = r_word_i;
    r_built[MOD_LSB +: MOD_W] = (step_i == ST_RSYNC) ? rsync_dly_i : modulus_i;
    r_built[RLOAD_BIT] = (step_i == ST_RSYNC);
    c_built = ctrl_word_i;
    c_built[CRST_BIT] = (step_i == ST_CTRL_RST);
  end

  always_comb begin
    unique case (step_i)
      ST_CLEAR:    word_o = '0;
      ST_NOISE:    word_o = noise_word_i;
      ST_CTRL_RST: word_o = c_built;
      ST_RSYNC:    word_o = r_built;
      ST_RLOAD:    word_o = r_built;
      ST_NLOAD:    word_o = n_word_i;
      ST_CTRL_RUN: word_o = c_built;
      default:     word_o = '0;
    endcase
  end
endmodule

// File: rtl/isq_shifter.sv
module isq_shifter
  import isq_pkg::*;
#(
  parameter int WORD_W     = 24,
  parameter int DIV_W      = 8,
  parameter int LE_HALVES  = 2,
  parameter int GAP_HALVES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              le_o,
  output logic              word_done_o
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int PH_W  = 3;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [PH_W-1:0]  LE_END   = PH_W'(LE_HALVES - 1);
  localparam logic [PH_W-1:0]  GAP_END  = PH_W'(GAP_HALVES - 1);

  sh_state_e         state_q, state_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic              sclk_q, sclk_d;
  logic              le_q, le_d;
  logic              tick;

  assign tick = (cnt_q == div_i);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ph_d    = ph_q;
    bit_d   = bit_q;
    shreg_d = shreg_q;
    sclk_d  = sclk_q;
    le_d    = le_q;
    if (state_q == SH_IDLE) begin
      if (load_i) begin
        state_d = SH_SHIFT;
        shreg_d = word_i;
        bit_d   = '0;
        cnt_d   = '0;
        sclk_d  = 1'b0;
      end
    end else begin
      cnt_d = tick ? '0 : cnt_q + 1'b1;
      if (tick) begin
        unique case (state_q)
          SH_SHIFT: begin
            if (!sclk_q) begin
              sclk_d = 1'b1;
            end else begin
              sclk_d = 1'b0;
              if (bit_q == LAST_BIT) begin
                state_d = SH_LATCH;
                le_d    = 1'b1;
                ph_d    = '0;
              end else begin
                bit_d   = bit_q + 1'b1;
                shreg_d = {shreg_q[WORD_W-2:0], 1'b0};
              end
            end
          end
          SH_LATCH: begin
            if (ph_q == LE_END) begin
              le_d    = 1'b0;
              state_d = SH_GAP;
              ph_d    = '0;
            end else begin
              ph_d = ph_q + 1'b1;
            end
          end
          SH_GAP: begin
            if (ph_q == GAP_END) state_d = SH_IDLE;
            else                 ph_d    = ph_q + 1'b1;
          end
          default: state_d = SH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      cnt_q   <= '0;
      ph_q    <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      sclk_q  <= 1'b0;
      le_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ph_q    <= ph_d;
      bit_q   <= bit_d;
      shreg_q <= shreg_d;
      sclk_q  <= sclk_d;
      le_q    <= le_d;
    end
  end

  assign sclk_o      = sclk_q;
  assign le_o        = le_q;
  assign sdata_o     = shreg_q[WORD_W-1] && (state_q == SH_SHIFT);
  assign word_done_o = (state_q == SH_GAP) && tick && (ph_q == GAP_END);

  // Strobe and serial clock are never high together
  assert_le_sclk_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(le_o && sclk_o));
  // Data holds across a whole high half
  assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));
  // A new word is only handed over once the idle gap has ended
  assert_load_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (state_q == SH_IDLE));
  // The strobe ends in a cycle with no shifting
  assert_le_fall_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(le_o) |-> !sdata_o);
endmodule

// File: rtl/isq_seq_ctrl.sv
module isq_seq_ctrl
  import isq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  logic  rsync_en_i,
  input  logic  word_done_i,
  output step_e step_o,
  output logic  load_o,
  output logic  done_o
);
  ct_state_e state_q, state_d;
  step_e     step_q, step_d;
  logic      done_q, done_d;
  step_e     step_nxt;

  always_comb begin
    unique case (step_q)
      ST_CLEAR:    step_nxt = ST_NOISE;
      ST_NOISE:    step_nxt = ST_CTRL_RST;
      ST_CTRL_RST: step_nxt = rsync_en_i ? ST_RSYNC : ST_RLOAD;
      ST_RSYNC:    step_nxt = ST_RLOAD;
      ST_RLOAD:    step_nxt = ST_NLOAD;
      ST_NLOAD:    step_nxt = ST_CTRL_RUN;
      default:     step_nxt = ST_CTRL_RUN;
    endcase
  end

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    done_d  = done_q;
    unique case (state_q)
      CT_ISSUE: state_d = CT_WAIT;
      CT_WAIT: begin
        if (word_done_i) begin
          if (step_q == ST_CTRL_RUN) begin
            state_d = CT_DONE;
            done_d  = 1'b1;
          end else begin
            state_d = CT_ISSUE;
            step_d  = step_nxt;
          end
        end
      end
      CT_DONE: begin
        if (start_i) begin
          state_d = CT_ISSUE;
          step_d  = ST_CLEAR;
          done_d  = 1'b0;
        end
      end
      default: state_d = CT_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CT_ISSUE;
      step_q  <= ST_CLEAR;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= done_d;
    end
  end

  assign step_o = step_q;
  assign load_o = (state_q == CT_ISSUE);
  assign done_o = done_q;

  // No word is issued once the run is complete
  assert_no_load_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !load_o);
  // Done holds until a start arrives
  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
  // A start during a run does not move the sequence
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != CT_DONE && start_i && !word_done_i) |=> $stable(step_q));
endmodule

// File: rtl/synth_init_seq.sv
module synth_init_seq
  import isq_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int DIV_W     = 8,
  parameter int MOD_W     = 12,
  parameter int MOD_LSB   = 3,
  parameter int RLOAD_BIT = WORD_W - 1,
  parameter int CRST_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  sclk_div_i,
  input  logic [WORD_W-1:0] noise_word_i,
  input  logic [WORD_W-1:0] ctrl_word_i,
  input  logic [WORD_W-1:0] r_word_i,
  input  logic [MOD_W-1:0]  modulus_i,
  input  logic [MOD_W-1:0]  rsync_dly_i,
  input  logic              rsync_en_i,
  input  logic [WORD_W-1:0] n_word_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              le_o,
  output logic              done_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_loc_n;
  step_e             step;
  logic              load;
  logic              word_done;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_loc_n = rst_pipe_q[1];

  isq_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_loc_n),
    .start_i     (start_i),
    .rsync_en_i  (rsync_en_i),
    .word_done_i (word_done),
    .step_o      (step),
    .load_o      (load),
    .done_o      (done_o)
  );

  isq_word_mux #(
    .WORD_W    (WORD_W),
    .MOD_W     (MOD_W),
    .MOD_LSB   (MOD_LSB),
    .RLOAD_BIT (RLOAD_BIT),
    .CRST_BIT  (CRST_BIT)
  ) u_mux (
    .step_i       (step),
    .noise_word_i (noise_word_i),
    .ctrl_word_i  (ctrl_word_i),
    .r_word_i     (r_word_i),
    .modulus_i    (modulus_i),
    .rsync_dly_i  (rsync_dly_i),
    .n_word_i     (n_word_i),
    .word_o       (word)
  );

  isq_shifter #(
    .WORD_W (WORD_W),
    .DIV_W  (DIV_W)
  ) u_shift (
    .clk         (clk),
    .rst_n       (rst_loc_n),
    .div_i       (sclk_div_i),
    .load_i      (load),
    .word_i      (word),
    .sclk_o      (sclk_o),
    .sdata_o     (sdata_o),
    .le_o        (le_o),
    .word_done_o (word_done)
  );

  // Counter reset must be set in the first control write
  assert_ctrl_rst_set_R4: assert property (@(posedge clk) disable iff (!rst_loc_n)
    (load && step == ST_CTRL_RST) |-> word[CRST_BIT]);
  // The normal reference-divider write selects the modulus
  assert_rload_bit_R5: assert property (@(posedge clk) disable iff (!rst_loc_n)
    (load && step == ST_RLOAD) |-> !word[RLOAD_BIT]);
endmodule

// File: tb/synth_init_seq_tb.sv
module synth_init_seq_tb;
  logic        clk;
  logic        rst_n;
  logic        start_r;
  logic [7:0]  div_r;
  logic [23:0] noise_r, ctrl_r, r_r, n_r;
  logic [11:0] mod_r, dly_r;
  logic        rs_r;
  logic        sclk, sdata, le, done;

  int nchk;
  int nfail;
  bit finished;

  logic [23:0] exp_w [0:6];
  string       kind  [0:6];

  synth_init_seq u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_r),
    .sclk_div_i   (div_r),
    .noise_word_i (noise_r),
    .ctrl_word_i  (ctrl_r),
    .r_word_i     (r_r),
    .modulus_i    (mod_r),
    .rsync_dly_i  (dly_r),
    .rsync_en_i   (rs_r),
    .n_word_i     (n_r),
    .sclk_o       (sclk),
    .sdata_o      (sdata),
    .le_o         (le),
    .done_o       (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input string sig, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, sig, $time, act, exp);
    end
  endtask

  task automatic chk_quiet(input string tag);
    chk(tag, "sclk", sclk, 1'b0);
    chk(tag, "sdata", sdata, 1'b0);
    chk(tag, "le", le, 1'b0);
    chk(tag, "done", done, 1'b0);
  endtask

  function automatic logic [23:0] rword(input logic ld, input logic [11:0] f);
    logic [23:0] v;
    v = r_r;
    v[14:3] = f;
    v[23] = ld;
    return v;
  endfunction

  task automatic build(output int nw);
    logic [23:0] c;
    nw = 0;
    exp_w[nw] = 24'h0; kind[nw] = "R2"; nw++;
    exp_w[nw] = noise_r; kind[nw] = "R2"; nw++;
    c = ctrl_r; c[2] = 1'b1;
    exp_w[nw] = c; kind[nw] = "R4"; nw++;
    if (rs_r) begin
      exp_w[nw] = rword(1'b1, dly_r); kind[nw] = "R3"; nw++;
    end
    exp_w[nw] = rword(1'b0, mod_r); kind[nw] = "R5"; nw++;
    exp_w[nw] = n_r; kind[nw] = "R2"; nw++;
    c[2] = 1'b0;
    exp_w[nw] = c; kind[nw] = "R4"; nw++;
  endtask

  // Model: t counts negedges after the edge that launches bit 23 of word 0
  task automatic follow(input int ign);
    int nw;
    int hh;
    int pp;
    build(nw);
    hh = int'(div_r) + 1;
    pp = 54 * hh + 1;
    for (int t = 0; t < nw * pp + 4; t++) begin
      int w;
      int u;
      int h;
      logic e_sclk, e_sdata, e_le, e_done;
      string tg;
      @(negedge clk);
      w = t / pp;
      u = t % pp;
      h = u / hh;
      e_sclk = 1'b0; e_sdata = 1'b0; e_le = 1'b0;
      e_done = (t >= nw * pp - 1);
      if (w < nw && u < 54 * hh) begin
        if (h < 48) begin
          e_sclk  = (h % 2) == 1;
          e_sdata = exp_w[w][23 - h / 2];
        end else if (h < 50) begin
          e_le = 1'b1;
        end
      end
      if (ign >= 0 && t > ign) begin
        chk("R10", "sclk", sclk, e_sclk);
        chk("R10", "sdata", sdata, e_sdata);
        chk("R10", "le", le, e_le);
        chk("R10", "done", done, e_done);
      end else begin
        if (w < nw && h < 48) tg = "R6";
        else if (w < nw && h < 50) tg = "R7";
        else tg = "R8";
        chk(tg, "sclk", sclk, e_sclk);
        chk(tg, "le", le, e_le);
        if (w < nw && h < 48) chk(kind[w], "sdata", sdata, e_sdata);
        else chk("R11", "sdata", sdata, e_sdata);
        chk("R9", "done", done, e_done);
      end
      start_r = (t == ign);
    end
  endtask

  task automatic reset_run();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk_quiet("R1");
    end
    rst_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk_quiet("R1");
    end
  endtask

  task automatic start_run();
    @(negedge clk);
    start_r = 1'b1;
    @(negedge clk);
    start_r = 1'b0;
    chk_quiet("R1");
  endtask

  initial begin
    nchk = 0; nfail = 0; finished = 0;
    rst_n = 1'b0; start_r = 1'b0;
    div_r = 8'd1; rs_r = 1'b0;
    noise_r = 24'h0003C7; ctrl_r = 24'h00A5A2; r_r = 24'h8FFF19;
    mod_r = 12'h041; dly_r = 12'h0C8; n_r = 24'h08A0F0;

    // Run 1: automatic sequence after reset, no resync (R1 R2 R4 R5)
    reset_run();
    follow(-1);

    // Run 2: start pulse, resync inserted, start during run ignored (R3 R10)
    div_r = 8'd3; rs_r = 1'b1;
    noise_r = 24'h123456; ctrl_r = 24'h5A5A5E; r_r = 24'h012340;
    mod_r = 12'h082; dly_r = 12'hABC; n_r = 24'hC3C3C3;
    start_run();
    follow(300);

    // Run 3: fastest serial clock, no resync
    div_r = 8'd0; rs_r = 1'b0;
    ctrl_r = 24'hFFFFFF; r_r = 24'h7FFFFF; n_r = 24'h800001;
    start_run();
    follow(-1);

    // Run 4: reset launches a resync sequence by itself
    div_r = 8'd2; rs_r = 1'b1; dly_r = 12'h001; mod_r = 12'hFFF;
    reset_run();
    follow(-1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule